// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers a set of level-sensitive interrupt request lines and gives a small processor core one interrupt line, plus the index of the source chosen for service. The request lines are not watched continuously. They are captured into a pending register only when the core pulses an instruction-boundary strobe. Any lines that change between two such strobes therefore count as simultaneous. A per-source mask removes individual lines from both signalling and arbitration.

A two-bit run-time mode selects the service discipline. Bit 1 picks nested (1) or single-level (0) service. Bit 0 picks ranked arbitration (1), where the highest index wins, or unranked arbitration (0), where the lowest index wins as a tie-break. When the core acknowledges, the winning index is latched onto the vector output, pushed onto an in-service stack as deep as the number of sources, and removed from the pending set. The global enable is cleared at the same time. The core sets and clears the enable through strobes. An end-of-service strobe pops the stack and brings back the previous level.

A source that is still asserted at a later boundary strobe is captured again and served again once the enable returns. A source that was captured as pending but is found low at a later boundary strobe, without having been served, raises a sticky lost-request flag. The next enable-set strobe clears that flag.

Top module: `npic_top`

## Requirements
- R1: The pending set changes only in a cycle with `sample_i` high. A change on `irq_i` without that strobe has no effect on `int_o` or on the vector chosen.
- R2: A line whose `mask_q` bit is 1 (written through `mask_wr_i`/`mask_i`, cleared to 0 at reset) never raises `int_o` and is never chosen as the vector.
- R3: `int_o` is high only while `ie_o` is high. `ie_set_i` sets the enable and `ie_clr_i` clears it, with clear winning when both are high. An accepted acknowledge (`ack_i` while `int_o`) clears the enable in the next cycle.
- R4: An accepted acknowledge latches the winner onto `vec_o`, raises `depth_o` by one, shows the winner on `act_o`, and drops that source from the pending set.
- R5: `eoi_i` at non-zero depth lowers `depth_o` by one and restores the previous entry on `act_o`. `eoi_i` at depth 0 is ignored.
- R6: With `mode_i[0]`=1 (ranked), the pending unmasked source with the highest index is chosen.
- R7: With `mode_i[0]`=0 (unranked), the pending unmasked source with the lowest index is chosen.
- R8: With `mode_i[1]`=0 (single-level), `int_o` stays low while `depth_o` is non-zero.
- R9: In mode 2'b11 (nested, ranked) at non-zero depth, `int_o` rises only for a pending source whose index is greater than `act_o`.
- R10: In mode 2'b10 (nested, unranked), any pending unmasked source that is not in service interrupts, whatever the current level.
- R11: A line still asserted after service is captured again at the next `sample_i` and signalled again once `ie_o` is set.
- R12: `ovf_o` is set when `sample_i` finds low an unmasked, not-in-service line that was pending. It is cleared by `ie_set_i`, and setting wins when both happen in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 2 | Bit 1: nested service; bit 0: ranked arbitration |
| irq_i | input | NSRC | Level request lines |
| sample_i | input | 1 | Instruction-boundary capture strobe |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_i | input | NSRC | Mask value, 1 blocks a line |
| ie_set_i | input | 1 | Set global enable |
| ie_clr_i | input | 1 | Clear global enable |
| ack_i | input | 1 | Acknowledge strobe |
| eoi_i | input | 1 | End-of-service strobe |
| int_o | output | 1 | Interrupt to the core |
| vec_o | output | $clog2(NSRC) | Latched source index |
| ie_o | output | 1 | Global enable state |
| act_o | output | $clog2(NSRC) | Source on top of the in-service stack |
| depth_o | output | $clog2(NSRC+1) | In-service stack depth |
| ovf_o | output | 1 | Sticky lost-request flag |

## Verification
A corrupted stack pointer or stack entry shows up on `depth_o` and `act_o` in the cycle after the strobe that caused it. It also appears as a wrong nesting decision on `int_o` for the next request. A bad pending or in-service bit shows as `int_o` rising or staying low at the first negative edge after the capture strobe, or as a wrong `vec_o` one cycle after acknowledge. The sweeps drive every request pattern of a four-source configuration in each mode, and for every in-service level, so a wrong arbitration slice or gating term is caught within a few cycles of its first use.

// File: rtl/npic_pkg.sv
package npic_pkg;

    typedef enum logic [1:0] {
        MD_FLAT_PLAIN = 2'b00,
        MD_FLAT_RANK  = 2'b01,
        MD_NEST_PLAIN = 2'b10,
        MD_NEST_RANK  = 2'b11
    } npic_mode_e;

endpackage

// File: rtl/npic_pick.sv
// Finds one set bit in a request vector; the parameter picks the search order.
module npic_pick #(
    parameter int N          = 4,
    parameter int IW         = $clog2(N),
    parameter bit HIGH_FIRST = 1'b1
) (
    input  logic [N-1:0]  req,
    output logic          hit,
    output logic [IW-1:0] idx
);

    generate
        if (HIGH_FIRST) begin : g_high
            always_comb begin
                hit = 1'b0;
                idx = '0;
                for (int i = 0; i < N; i++) begin
                    if (req[i]) begin
                        hit = 1'b1;
                        idx = IW'(i);
                    end
                end
            end
        end else begin : g_low
            always_comb begin
                hit = 1'b0;
                idx = '0;
                for (int i = N - 1; i >= 0; i--) begin
                    if (req[i]) begin
                        hit = 1'b1;
                        idx = IW'(i);
                    end
                end
            end
        end
    endgenerate

endmodule

// File: rtl/npic_stack.sv
// In-service stack: one entry per source, plus a bit vector of live sources.
module npic_stack #(
    parameter int N  = 4,
    parameter int IW = $clog2(N),
    parameter int DW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic [IW-1:0] push_idx,
    output logic [DW-1:0] depth,
    output logic [IW-1:0] top,
    output logic [N-1:0]  live
);

    typedef struct packed {
        logic [N-1:0][IW-1:0] stk;
        logic [DW-1:0]        depth;
        logic [N-1:0]         live;
    } stk_state_t;

    stk_state_t st_q, st_d;
    logic [DW-1:0] dm1;

    always_comb begin
        st_d = st_q;
        dm1  = st_q.depth - 1'b1;
        if (push && (st_q.depth < DW'(N))) begin
            st_d.stk[st_q.depth[IW-1:0]] = push_idx;
            st_d.depth                   = st_q.depth + 1'b1;
            st_d.live[push_idx]          = 1'b1;
        end else if (pop && (st_q.depth != '0)) begin
            st_d.live[st_q.stk[dm1[IW-1:0]]] = 1'b0;
            st_d.depth                       = dm1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign depth = st_q.depth;
    assign live  = st_q.live;
    assign top   = (st_q.depth == '0) ? '0 : st_q.stk[dm1[IW-1:0]];

endmodule

// File: rtl/npic_top.sv
module npic_top
    import npic_pkg::*;
#(
    parameter int NSRC = 4,
    parameter int IW   = $clog2(NSRC),
    parameter int DW   = $clog2(NSRC + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      mode_i,
    input  logic [NSRC-1:0] irq_i,
    input  logic            sample_i,
    input  logic            mask_wr_i,
    input  logic [NSRC-1:0] mask_i,
    input  logic            ie_set_i,
    input  logic            ie_clr_i,
    input  logic            ack_i,
    input  logic            eoi_i,
    output logic            int_o,
    output logic [IW-1:0]   vec_o,
    output logic            ie_o,
    output logic [IW-1:0]   act_o,
    output logic [DW-1:0]   depth_o,
    output logic            ovf_o
);

    typedef struct packed {
        logic [NSRC-1:0] pend;
        logic [NSRC-1:0] mask;
        logic            ie;
        logic [IW-1:0]   vec;
        logic            ovf;
    } ctl_state_t;

    ctl_state_t st_q, st_d;

    npic_mode_e      md;
    logic [NSRC-1:0] eff;
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] mask_cur;
    logic [NSRC-1:0] gone;
    logic            hit_hi, hit_lo, hit;
    logic [IW-1:0]   idx_hi, idx_lo, win;
    logic            gate;
    logic            take;
    logic            pop;
    logic [IW-1:0]   top;
    logic [DW-1:0]   depth;

    assign md       = npic_mode_e'(mode_i);
    assign mask_cur = st_q.mask;
    assign eff      = st_q.pend & ~st_q.mask & ~live;

    npic_pick #(.N(NSRC), .IW(IW), .HIGH_FIRST(1'b1)) u_pick_hi (
        .req (eff),
        .hit (hit_hi),
        .idx (idx_hi)
    );

    npic_pick #(.N(NSRC), .IW(IW), .HIGH_FIRST(1'b0)) u_pick_lo (
        .req (eff),
        .hit (hit_lo),
        .idx (idx_lo)
    );

    npic_stack #(.N(NSRC), .IW(IW), .DW(DW)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (take),
        .pop      (pop),
        .push_idx (win),
        .depth    (depth),
        .top      (top),
        .live     (live)
    );

    // arbitration and nesting gate
    always_comb begin
        hit = mode_i[0] ? hit_hi : hit_lo;
        win = mode_i[0] ? idx_hi : idx_lo;
        unique case (md)
            MD_FLAT_PLAIN, MD_FLAT_RANK: gate = (depth == '0);
            MD_NEST_PLAIN:               gate = 1'b1;
            MD_NEST_RANK:                gate = (depth == '0) || (win > top);
            default:                     gate = 1'b0;
        endcase
        int_o = st_q.ie & hit & gate;
        take  = ack_i & int_o;
        pop   = eoi_i & ~take;
    end

    // next state
    always_comb begin
        st_d = st_q;
        gone = st_q.pend & ~st_q.mask & ~live & ~irq_i;
        if (ie_set_i) begin
            st_d.ie  = 1'b1;
            st_d.ovf = 1'b0;
        end
        if (ie_clr_i) begin
            st_d.ie = 1'b0;
        end
        if (sample_i) begin
            st_d.pend = irq_i;
            if (gone != '0) begin
                st_d.ovf = 1'b1;
            end
        end
        if (mask_wr_i) begin
            st_d.mask = mask_i;
        end
        if (take) begin
            st_d.ie        = 1'b0;
            st_d.vec       = win;
            st_d.pend[win] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_o   = st_q.vec;
    assign ie_o    = st_q.ie;
    assign ovf_o   = st_q.ovf;
    assign act_o   = top;
    assign depth_o = depth;

endmodule

// File: rtl/npic_chk.sv
module npic_chk #(
    parameter int NSRC = 4,
    parameter int IW   = $clog2(NSRC),
    parameter int DW   = $clog2(NSRC + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      mode_i,
    input logic            ack_i,
    input logic            eoi_i,
    input logic            int_o,
    input logic            ie_o,
    input logic [IW-1:0]   vec_o,
    input logic [IW-1:0]   act_o,
    input logic [DW-1:0]   depth_o,
    input logic [NSRC-1:0] mask_cur
);

    assert_int_needs_ie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> ie_o);

    assert_ack_drops_ie_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o) |=> !ie_o);

    assert_push_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o) |=> (depth_o == DW'($past(depth_o) + 1'b1)) && (act_o == vec_o));

    assert_pop_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !(ack_i && int_o) && depth_o != '0) |=> depth_o == DW'($past(depth_o) - 1'b1));

    assert_masked_never_won_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o) |=> (($past(mask_cur) & ({{(NSRC-1){1'b0}}, 1'b1} << vec_o)) == '0));

    assert_flat_no_nest_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i[1] && depth_o != '0) |-> !int_o);

    assert_rank_climbs_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && int_o && mode_i == 2'b11 && depth_o != '0) |=> vec_o > $past(act_o));

    assert_depth_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        depth_o <= DW'(NSRC));

endmodule

bind npic_top npic_chk #(.NSRC(NSRC), .IW(IW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_i   (mode_i),
    .ack_i    (ack_i),
    .eoi_i    (eoi_i),
    .int_o    (int_o),
    .ie_o     (ie_o),
    .vec_o    (vec_o),
    .act_o    (act_o),
    .depth_o  (depth_o),
    .mask_cur (mask_cur)
);

// File: tb/sim_npic_top.sv
module sim_npic_top;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int IW = 2;
    localparam int DW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    mode_i = '0;
    logic [N-1:0]  irq_i = '0;
    logic          sample_i = 1'b0;
    logic          mask_wr_i = 1'b0;
    logic [N-1:0]  mask_i = '0;
    logic          ie_set_i = 1'b0;
    logic          ie_clr_i = 1'b0;
    logic          ack_i = 1'b0;
    logic          eoi_i = 1'b0;
    logic          int_o;
    logic [IW-1:0] vec_o;
    logic          ie_o;
    logic [IW-1:0] act_o;
    logic [DW-1:0] depth_o;
    logic          ovf_o;

    int n_run  = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    npic_top #(.NSRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .irq_i(irq_i),
        .sample_i(sample_i), .mask_wr_i(mask_wr_i), .mask_i(mask_i),
        .ie_set_i(ie_set_i), .ie_clr_i(ie_clr_i), .ack_i(ack_i), .eoi_i(eoi_i),
        .int_o(int_o), .vec_o(vec_o), .ie_o(ie_o), .act_o(act_o),
        .depth_o(depth_o), .ovf_o(ovf_o)
    );

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int hi_of(input int p);
        int r = -1;
        for (int i = 0; i < N; i++) if (p[i]) r = i;
        return r;
    endfunction

    function automatic int lo_of(input int p);
        int r = -1;
        for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic sample(input logic [N-1:0] p);
        irq_i = p; sample_i = 1'b1;
        @(negedge clk);
        sample_i = 1'b0;
    endtask

    task automatic ie_set();
        ie_set_i = 1'b1;
        @(negedge clk);
        ie_set_i = 1'b0;
    endtask

    task automatic ack();
        ack_i = 1'b1;
        @(negedge clk);
        ack_i = 1'b0;
    endtask

    task automatic eoi();
        eoi_i = 1'b1;
        @(negedge clk);
        eoi_i = 1'b0;
    endtask

    task automatic set_mask(input logic [N-1:0] m);
        mask_i = m; mask_wr_i = 1'b1;
        @(negedge clk);
        mask_wr_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // reset state
        chk(!int_o && !ie_o && !ovf_o && depth_o == 0 && vec_o == 0, "R3 reset", int'(int_o), 0);

        // Sweep A: every mode, every pattern from idle
        for (int m = 0; m < 4; m++) begin
            for (int p = 0; p < 16; p++) begin
                int w, rest, exp_int;
                mode_i = 2'(m);
                do_reset();
                ie_set();
                sample(4'(p));
                chk(int_o == (p != 0), "R1 capture", int'(int_o), int'(p != 0));
                if (p != 0) begin
                    w = (m % 2 == 1) ? hi_of(p) : lo_of(p);
                    ack();
                    chk(vec_o == w, (m % 2 == 1) ? "R6 ranked pick" : "R7 unranked pick", vec_o, w);
                    chk(!ie_o && !int_o, "R3 ack clears enable", int'(ie_o), 0);
                    chk(depth_o == 1 && act_o == w, "R4 push", act_o, w);
                    ie_set();
                    rest = p & ~(1 << w);
                    if (m < 2) exp_int = 0;
                    else if (m == 2) exp_int = (rest != 0);
                    else exp_int = (hi_of(rest) > w);
                    chk(int_o == exp_int, (m < 2) ? "R8 no nest" : ((m == 2) ? "R10 any preempts" : "R9 higher only"),
                        int'(int_o), exp_int);
                    if (m < 2) begin
                        eoi();
                        chk(depth_o == 0 && int_o == (rest != 0), "R5 pop and R8 resume", int'(int_o), int'(rest != 0));
                    end
                end
            end
        end

        // Sweep B: nested ranked, every in-service level and pattern
        mode_i = 2'b11;
        for (int s = 0; s < N; s++) begin
            for (int p = 0; p < 16; p++) begin
                int h, exp_int;
                do_reset();
                ie_set();
                sample(4'(1 << s));
                ack();
                ie_set();
                sample(4'(p));
                h = hi_of(p);
                exp_int = (h > s);
                chk(int_o == exp_int, "R9 preempt rule", int'(int_o), exp_int);
                if (exp_int != 0) begin
                    ack();
                    chk(vec_o == h && act_o == h && depth_o == 2, "R9 nested vector", vec_o, h);
                    eoi();
                    chk(depth_o == 1 && act_o == s, "R5 restore level", act_o, s);
                end
            end
        end

        // R2 mask
        mode_i = 2'b01;
        do_reset();
        set_mask(4'b1000);
        ie_set();
        sample(4'b1010);
        ack();
        chk(vec_o == 1, "R2 masked loses", vec_o, 1);
        do_reset();
        set_mask(4'b1111);
        ie_set();
        sample(4'b1111);
        chk(!int_o, "R2 all masked", int'(int_o), 0);

        // R1 change between strobes ignored
        do_reset();
        ie_set();
        sample(4'b0001);
        irq_i = 4'b1000;
        repeat (3) @(negedge clk);
        ack();
        chk(vec_o == 0, "R1 no capture without strobe", vec_o, 0);

        // R3 clear wins over set
        do_reset();
        ie_set_i = 1'b1; ie_clr_i = 1'b1;
        @(negedge clk);
        ie_set_i = 1'b0; ie_clr_i = 1'b0;
        chk(!ie_o, "R3 clear wins", int'(ie_o), 0);

        // R5 eoi at depth 0 ignored
        eoi();
        chk(depth_o == 0, "R5 empty pop", depth_o, 0);

        // R11 uncleared cause is taken again
        mode_i = 2'b00;
        do_reset();
        ie_set();
        sample(4'b0100);
        ack();
        sample(4'b0100);
        eoi();
        chk(!int_o, "R11 waits for enable", int'(int_o), 0);
        ie_set();
        chk(int_o, "R11 retaken", int'(int_o), 1);
        ack();
        chk(vec_o == 2, "R11 same vector", vec_o, 2);

        // R12 lost request flag
        do_reset();
        sample(4'b0010);
        sample(4'b0000);
        chk(ovf_o, "R12 dropped sets flag", int'(ovf_o), 1);
        ie_set();
        chk(!ovf_o, "R12 enable clears flag", int'(ovf_o), 0);
        do_reset();
        ie_set();
        sample(4'b0010);
        ack();
        sample(4'b0000);
        chk(!ovf_o, "R12 served is not lost", int'(ovf_o), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule